// File: doc/BRIEF.md
# Edge-Triggered Status Interrupt Controller

This block watches a group of slow status lines, three per port (called A, B and C) across a configurable number of ports. When a line makes a transition that the host has armed, the block raises one shared host interrupt. Every line has its own trigger selection: off, rising transitions, falling transitions, or both. A latched flag records which line and which direction caused each event. The flag stays set until the host clears it.

The interrupt output is an output-enable. When it is high, the pad pulls a shared active-low line to ground. When it is low, the pad is released, so several devices can share one interrupt wire. The host reaches the block through a small synchronous register port. From it the host can read the live line levels, set the trigger selection, read and clear the flags, and read a summary word with one bit per port. The host transport that carries these accesses is outside this block.

All line inputs pass through a two-flop synchroniser before edge detection. An armed edge reaches the interrupt output in a fixed four clock cycles. At any realistic clock rate this is far below 50 µs.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, `host_int_oe` is 0, every flag is 0 and every trigger selection reads back as 0 (off).
- R2: Register address is {port, sel[1:0]}. `reg_rdata` shows, one cycle after `reg_addr` is presented, the register at that address. With sel=0 it shows the synchronised levels as bits [2:0] = {C,B,A}.
- R3: The trigger selection register is at sel=1. Line i (A=0, B=1, C=2) owns bits [2i+1:2i], and bit 2i arms rising edges. A 0-to-1 transition on an armed line sets rising flag i. A 1-to-0 transition on it sets nothing.
- R4: Bit 2i+1 of the selection register arms falling edges. A 1-to-0 transition sets falling flag i. A 0-to-1 transition on a line armed only for falling sets nothing.
- R5: With both bits of a line set (value 3), either transition sets the flag matching its direction.
- R6: With a line's selection at 0, transitions on it set no flag and cause no interrupt.
- R7: The flag register is at sel=2. Bits [2:0] are the rising flags for {C,B,A} and bits [5:3] are the falling flags for {C,B,A}. Writing 1 to a bit clears it and writing 0 leaves it alone. A flag never clears by itself.
- R8: `host_int_oe` rises on the fourth rising clock edge after an armed transition reaches the input pin. It stays high while any armed flag is set, and it falls on the clock edge after the last one is cleared.
- R9: The summary register is at sel=3, at any port value. Bit p is 1 when port p holds at least one armed flag.
- R10: Turning off a line's selection removes its existing flags from the summary and from the interrupt. The flag bits themselves stay readable.
- R11: Writes to sel=0 and sel=3 change no register, no flag and not the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NPORT*3 | Status lines; port p uses bits [3p+2:3p] = {C,B,A} |
| reg_addr | input | PORT_W+2 | Register address {port, sel} |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| host_int_oe | output | 1 | 1 = pull shared interrupt line low |

## Verification
The assertions assume that the status lines are slow next to the clock. Every transition must stay stable long enough to pass the synchroniser, so no pulse is shorter than the detection path. They also assume that register writes are single-cycle strobes, since a falling interrupt is linked back to a write in the cycle before. The stimulus holds each line level for at least several cycles before changing it. It drives all inputs only on the falling clock edge, and it raises `reg_we` for exactly one cycle per access.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int unsigned LINES = 3;
    localparam int unsigned MODE_W = 2 * LINES;
    localparam int unsigned FLAG_W = 2 * LINES;

    typedef enum logic [1:0] {
        SEL_LEVEL   = 2'd0,
        SEL_MODE    = 2'd1,
        SEL_FLAG    = 2'd2,
        SEL_SUMMARY = 2'd3
    } sel_e;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int unsigned W      = 12,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/eic_port.sv
module eic_port
    import eic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  lvl_i,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              clr_we,
    input  logic [FLAG_W-1:0] clr_mask,
    output logic [MODE_W-1:0] mode_o,
    output logic [FLAG_W-1:0] flag_o,
    output logic              pend_o
);
    typedef struct packed {
        logic [LINES-1:0]  prev;
        logic [MODE_W-1:0] mode;
        logic [FLAG_W-1:0] flag;
    } port_s;

    port_s st_d, st_q;
    logic [LINES-1:0]  rise_en, fall_en, rise_ev, fall_ev;
    logic [FLAG_W-1:0] set_v, armed;

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            rise_en[i] = st_q.mode[2*i];
            fall_en[i] = st_q.mode[2*i+1];
        end
        rise_ev = lvl_i & ~st_q.prev;
        fall_ev = ~lvl_i & st_q.prev;
        set_v   = {fall_ev & fall_en, rise_ev & rise_en};
        armed   = {fall_en, rise_en};

        st_d      = st_q;
        st_d.prev = lvl_i;
        if (mode_we) st_d.mode = mode_wdata;
        st_d.flag = (st_q.flag & ~(clr_we ? clr_mask : '0)) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o = st_q.mode;
    assign flag_o = st_q.flag;
    assign pend_o = |(st_q.flag & armed);

    for (genvar i = 0; i < LINES; i++) begin : g_chk
        // R6: a flag only appears for a direction that was armed
        p_rise_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.flag[i]) |-> $past(st_q.mode[2*i]));
        p_fall_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.flag[LINES+i]) |-> $past(st_q.mode[2*i+1]));
    end

    for (genvar j = 0; j < FLAG_W; j++) begin : g_sticky
        // R7: flags fall only through a write-one-to-clear
        p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.flag[j]) |-> $past(clr_we && clr_mask[j]));
    end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import eic_pkg::*;
#(
    parameter int unsigned NPORT       = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_W      = 8,
    localparam int unsigned PORT_W     = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int unsigned ADDR_W     = PORT_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORT*LINES-1:0] line_i,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic                   reg_we,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    output logic                   host_int_oe
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              oe;
    } top_s;

    top_s top_d, top_q;

    logic [NPORT*LINES-1:0]         lvl_s;
    logic [NPORT-1:0][MODE_W-1:0]   mode_all;
    logic [NPORT-1:0][FLAG_W-1:0]   flag_all;
    logic [NPORT-1:0]               pend_all;
    logic [NPORT-1:0]               mode_we_v, clr_we_v;
    logic [PORT_W-1:0]              port_idx;
    sel_e                           sel;

    assign port_idx = reg_addr[ADDR_W-1:2];
    assign sel      = sel_e'(reg_addr[1:0]);

    eic_sync #(.W(NPORT*LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_i),
        .dout (lvl_s)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign mode_we_v[p] = reg_we && (sel == SEL_MODE) && (port_idx == PORT_W'(p));
        assign clr_we_v[p]  = reg_we && (sel == SEL_FLAG) && (port_idx == PORT_W'(p));

        eic_port u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl_i     (lvl_s[p*LINES +: LINES]),
            .mode_we   (mode_we_v[p]),
            .mode_wdata(reg_wdata[MODE_W-1:0]),
            .clr_we    (clr_we_v[p]),
            .clr_mask  (reg_wdata[FLAG_W-1:0]),
            .mode_o    (mode_all[p]),
            .flag_o    (flag_all[p]),
            .pend_o    (pend_all[p])
        );
    end

    always_comb begin
        top_d       = top_q;
        top_d.oe    = |pend_all;
        top_d.rdata = '0;
        if (sel == SEL_SUMMARY) begin
            top_d.rdata = DATA_W'(pend_all);
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (port_idx == PORT_W'(p)) begin
                    case (sel)
                        SEL_LEVEL: top_d.rdata = DATA_W'(lvl_s[p*LINES +: LINES]);
                        SEL_MODE:  top_d.rdata = DATA_W'(mode_all[p]);
                        SEL_FLAG:  top_d.rdata = DATA_W'(flag_all[p]);
                        default:   top_d.rdata = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign reg_rdata   = top_q.rdata;
    assign host_int_oe = top_q.oe;

    // R8: any pending armed flag pulls the line on the next edge
    p_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_all) |=> host_int_oe);
    // R8: with nothing pending the line is released on the next edge
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend_all) |=> !host_int_oe);
    // R7: the interrupt only drops after a host write
    p_drop_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_int_oe) |-> $past(reg_we, 2));
endmodule

// File: tb/sim_edge_irq_ctrl.sv
module sim_edge_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] line_i = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        host_int_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    edge_irq_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_i),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .host_int_oe(host_int_oe)
    );

    // {port, mode, start, end, expected flags}
    localparam logic [19:0] VEC [8] = '{
        {2'd0, 6'b010101, 3'b000, 3'b111, 6'h07},
        {2'd0, 6'b010101, 3'b111, 3'b000, 6'h00},
        {2'd1, 6'b101010, 3'b111, 3'b000, 6'h38},
        {2'd1, 6'b101010, 3'b000, 3'b101, 6'h00},
        {2'd2, 6'b111111, 3'b010, 3'b101, 6'h15},
        {2'd3, 6'b000000, 3'b000, 3'b111, 6'h00},
        {2'd3, 6'b111001, 3'b110, 3'b001, 6'h31},
        {2'd2, 6'b000001, 3'b000, 3'b111, 6'h01}
    };

    function automatic logic [3:0] adr(input int p, input int s);
        return {2'(p), 2'(s)};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        @(posedge clk); @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic lines(input int p, input logic [2:0] v);
        line_i[p*3 +: 3] = v;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        check("R1 oe", 8'(host_int_oe), 8'h0);
        rd(adr(2, 1), d); check("R1 mode", d, 8'h00);
        rd(adr(2, 2), d); check("R1 flags", d, 8'h00);
        rd(adr(0, 3), d); check("R1 summary", d, 8'h00);

        foreach (VEC[k]) begin
            int p;
            p = int'(VEC[k][19:18]);
            wr(adr(p, 1), 8'(VEC[k][17:12]));
            lines(p, VEC[k][11:9]);
            cyc(6);
            wr(adr(p, 2), 8'h3F);
            cyc(2);
            lines(p, VEC[k][8:6]);
            cyc(6);
            rd(adr(p, 2), d);
            check("R3/R4/R5/R6 vector flags", d, 8'(VEC[k][5:0]));
            check("R8 vector oe", 8'(host_int_oe), 8'(VEC[k][5:0] != 0));
            wr(adr(p, 2), 8'h3F);
            wr(adr(p, 1), 8'h00);
            lines(p, 3'b000);
            cyc(4);
        end

        // R2 live levels
        lines(1, 3'b101); lines(3, 3'b011);
        cyc(4);
        rd(adr(1, 0), d); check("R2 level p1", d, 8'h05);
        rd(adr(3, 0), d); check("R2 level p3", d, 8'h03);
        lines(1, 3'b000); lines(3, 3'b000);
        cyc(4);

        // R8 latency: armed rising A on port 0
        wr(adr(0, 1), 8'h01);
        lines(0, 3'b001);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 not before 4th edge", 8'(host_int_oe), 8'h0);
        @(posedge clk); @(negedge clk);
        check("R8 at 4th edge", 8'(host_int_oe), 8'h1);

        // R7 partial write-one-to-clear
        wr(adr(0, 1), 8'h15);
        lines(0, 3'b111);
        cyc(6);
        rd(adr(0, 2), d); check("R7 flags set", d, 8'h07);
        wr(adr(0, 2), 8'h01);
        rd(adr(0, 2), d); check("R7 partial clear", d, 8'h06);
        check("R7 oe held", 8'(host_int_oe), 8'h1);
        wr(adr(0, 2), 8'h06);
        rd(adr(0, 2), d); check("R7 full clear", d, 8'h00);
        check("R8 oe released", 8'(host_int_oe), 8'h0);
        wr(adr(0, 1), 8'h00);
        lines(0, 3'b000);
        cyc(4);

        // R9 summary
        wr(adr(1, 1), 8'h3F); wr(adr(3, 1), 8'h3F);
        lines(1, 3'b100); lines(3, 3'b010);
        cyc(6);
        rd(adr(2, 3), d); check("R9 summary", d, 8'h0A);

        // R11 writes to read-only selections
        wr(adr(0, 0), 8'hFF);
        wr(adr(2, 3), 8'hFF);
        rd(adr(0, 3), d); check("R11 summary kept", d, 8'h0A);
        rd(adr(1, 2), d); check("R11 flags kept", d, 8'h04);
        rd(adr(1, 1), d); check("R11 mode kept", d, 8'h3F);
        check("R11 oe kept", 8'(host_int_oe), 8'h1);

        // R10 disarm masks but keeps flags
        wr(adr(1, 1), 8'h00);
        rd(adr(0, 3), d); check("R10 summary masked", d, 8'h08);
        rd(adr(1, 2), d); check("R10 flag kept", d, 8'h04);
        wr(adr(3, 1), 8'h00);
        cyc(2);
        check("R10 oe released", 8'(host_int_oe), 8'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule